// File: doc/BRIEF.md
# Hashed Page Table Walker

This block translates a 32-bit virtual address to a physical address by searching a hashed page table in memory. A request carries the address, an instruction-fetch flag, a write flag and the problem-state (user) bit. The top four address bits select one of sixteen segment registers. That register supplies the virtual segment identifier, two protection keys and a no-execute bit. A table configuration word gives the table base and a hash mask. From these the walker computes a primary and a secondary group address and a 32-bit compare word.

The walker reads the upper word of each 8-byte entry, one word per memory access, through a request/valid port. It scans the primary group first and the secondary group only if the primary group has no match. On the first match it reads the lower word of that entry, evaluates the permission and forms the physical address. A single-cycle done pulse marks the result. Both group addresses stay readable after every walk, including walks that hit in the primary group.

Top module: `hpt_walker`

## Requirements
- R1: After reset `done_o`, `found_o`, `busy_o` and `mem_req_o` are 0, and `perm_o` is 0.
- R2: The segment index is vaddr[31:28], and the VSID is bits 23:0 of that segment register. Primary hash (19 bits) = VSID[18:0] XOR {3'b0, vaddr[27:12]}. Group address = {cfg[31:25], cfg[24:16] OR (hash[18:10] AND cfg[8:0]), hash[9:0], 6'b0}. `grp_pri_o` shows this address from the cycle after a request is accepted.
- R3: `grp_sec_o` is built with the same formula from the primary hash XOR 0x7FFFF. Both addresses are latched on every walk.
- R4: The compare word is {1 (valid, bit 31), VSID (bits 30:7), H (bit 6), vaddr[27:22] (bits 5:0)}. An entry i of a group has its upper word at group+8·i and its lower word at group+8·i+4. The lower word is read only for a matching entry.
- R5: The secondary group is searched only after all 8 primary entries miss, and its compare word has H=1. If both groups miss, the result is `found_o`=0, `perm_o`=0 and `paddr_o`=0.
- R6: Segment bit 28 is no-execute, and lower-word bit 3 is guarded. An instruction fetch that matches in a no-execute segment or on a guarded page gives `found_o`=1 and `perm_o`=0. Neither bit affects data accesses.
- R7: The key is segment bit 29 when user=1 and segment bit 30 when user=0. With the key set, protection bits pp (lower[1:0]) give: 0 → 0 (none), 2 → 2 (read-write), 1 or 3 → 1 (read-only), or 0 on a write.
- R8: With the key clear, pp=3 gives 1 (0 on a write), and every other pp value gives 2.
- R9: On a hit, `paddr_o` = {lower[31:12], vaddr[11:0]}.
- R10: `mem_req_o` stays high and `mem_addr_o` stays unchanged until `mem_valid_i` returns the word. Only one read is outstanding at a time.
- R11: `done_o` is a one-cycle pulse in the cycle after the final read data. Requests that arrive while `busy_o` is high are ignored.
- R12: The walk stops at the first match. A hit in primary slot s takes s+2 reads, a hit in secondary slot s takes s+10 reads, and a full miss takes 16 reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| req_valid_i | input | 1 | Start a walk (accepted when idle) |
| req_vaddr_i | input | 32 | Virtual address |
| req_instr_i | input | 1 | Instruction fetch |
| req_write_i | input | 1 | Write access |
| req_user_i | input | 1 | Problem-state (user) bit |
| seg_regs_i | input | 512 | Sixteen 32-bit segment registers, register n at bits 32n+31:32n |
| tbl_cfg_i | input | 32 | Table base [31:16], hash mask [8:0] |
| mem_req_o | output | 1 | Read request, held until data returns |
| mem_addr_o | output | 32 | Byte address of the word read |
| mem_valid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Read data word |
| busy_o | output | 1 | Walk in progress |
| done_o | output | 1 | Result pulse |
| found_o | output | 1 | Matching entry found |
| paddr_o | output | 32 | Physical address |
| perm_o | output | 2 | 0 none, 1 read-only, 2 read-write |
| grp_pri_o | output | 32 | Primary group address |
| grp_sec_o | output | 32 | Secondary group address |

## Verification
Both group addresses are due one clock after the accepting edge, so the bench samples them at the first falling edge after it drops `req_valid_i`. The walk results are due in the cycle of `done_o`, one clock after the last data beat. The bench waits for `done_o` at falling edges and compares `found_o`, `perm_o`, `paddr_o` and the read count in that same cycle, then checks that `done_o` is low one cycle later. The memory model keeps each read pending for one cycle, checks that the address has held, and then returns the word.

// File: rtl/hpt_pkg.sv
`timescale 1ns/1ps
package hpt_pkg;
  typedef enum logic [1:0] {ST_IDLE = 2'd0, ST_UP = 2'd1, ST_LO = 2'd2} walk_st_e;

  localparam logic [1:0] PERM_NONE = 2'd0;
  localparam logic [1:0] PERM_RO   = 2'd1;
  localparam logic [1:0] PERM_RW   = 2'd2;

  localparam int WORD_W     = 32;
  localparam int VSID_W     = 24;
  localparam int HASH_W     = 19;
  localparam int PIDX_W     = 16;
  localparam int SEG_KS_BIT = 30;
  localparam int SEG_KP_BIT = 29;
  localparam int SEG_NX_BIT = 28;
  localparam int PTE_H_BIT  = 6;
  localparam int PTE_G_BIT  = 3;
  localparam int ENTRY_B    = 8;
endpackage

// File: rtl/hpt_hash.sv
`timescale 1ns/1ps
module hpt_hash
  import hpt_pkg::*;
(
  input  logic [VSID_W-1:0] vsid_i,
  input  logic [PIDX_W-1:0] page_idx_i,
  input  logic [WORD_W-1:0] cfg_i,
  output logic [WORD_W-1:0] grp_pri_o,
  output logic [WORD_W-1:0] grp_sec_o,
  output logic [WORD_W-1:0] cmp_o
);
  logic [HASH_W-1:0] hash_base;
  logic [WORD_W-1:0] grp [2];
  logic              unused_cfg;

  assign hash_base = vsid_i[HASH_W-1:0] ^ {{(HASH_W-PIDX_W){1'b0}}, page_idx_i};

  for (genvar h = 0; h < 2; h++) begin : g_grp
    localparam logic [HASH_W-1:0] FLIP = (h == 1) ? {HASH_W{1'b1}} : '0;
    logic [HASH_W-1:0] hv;
    assign hv     = hash_base ^ FLIP;
    assign grp[h] = {cfg_i[31:25], cfg_i[24:16] | (hv[18:10] & cfg_i[8:0]), hv[9:0], 6'b0};
  end

  assign grp_pri_o  = grp[0];
  assign grp_sec_o  = grp[1];
  assign cmp_o      = {1'b1, vsid_i, 1'b0, page_idx_i[15:10]};
  assign unused_cfg = ^cfg_i[15:9];
endmodule

// File: rtl/hpt_perm.sv
`timescale 1ns/1ps
module hpt_perm
  import hpt_pkg::*;
(
  input  logic       instr_i,
  input  logic       write_i,
  input  logic       user_i,
  input  logic       ks_i,
  input  logic       kp_i,
  input  logic       nx_i,
  input  logic       guard_i,
  input  logic [1:0] pp_i,
  output logic [1:0] perm_o
);
  logic key;
  assign key = user_i ? kp_i : ks_i;

  always_comb begin
    if (instr_i && (nx_i || guard_i)) begin
      perm_o = PERM_NONE;
    end else if (key) begin
      case (pp_i)
        2'd0:    perm_o = PERM_NONE;
        2'd2:    perm_o = PERM_RW;
        default: perm_o = write_i ? PERM_NONE : PERM_RO;
      endcase
    end else begin
      perm_o = (pp_i == 2'd3) ? (write_i ? PERM_NONE : PERM_RO) : PERM_RW;
    end
  end
endmodule

// File: rtl/hpt_walker.sv
`timescale 1ns/1ps
module hpt_walker
  import hpt_pkg::*;
#(
  parameter int N_SEG   = 16,
  parameter int N_SLOTS = 8
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    req_valid_i,
  input  logic [WORD_W-1:0]       req_vaddr_i,
  input  logic                    req_instr_i,
  input  logic                    req_write_i,
  input  logic                    req_user_i,
  input  logic [N_SEG*WORD_W-1:0] seg_regs_i,
  input  logic [WORD_W-1:0]       tbl_cfg_i,
  output logic                    mem_req_o,
  output logic [WORD_W-1:0]       mem_addr_o,
  input  logic                    mem_valid_i,
  input  logic [WORD_W-1:0]       mem_rdata_i,
  output logic                    busy_o,
  output logic                    done_o,
  output logic                    found_o,
  output logic [WORD_W-1:0]       paddr_o,
  output logic [1:0]              perm_o,
  output logic [WORD_W-1:0]       grp_pri_o,
  output logic [WORD_W-1:0]       grp_sec_o
);
  localparam int SEG_IW = $clog2(N_SEG);
  localparam int SLOT_W = $clog2(N_SLOTS);
  localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(N_SLOTS - 1);
  localparam int OFF_W  = 12;

  walk_st_e          st_q;
  logic [SLOT_W-1:0] idx_q;
  logic              sec_q, ins_q, wr_q, usr_q;
  logic              ks_q, kp_q, nx_q;
  logic [OFF_W-1:0]  off_q;
  logic [WORD_W-1:0] cmp_q, grp_pri_q, grp_sec_q;
  logic              done_q, found_q;
  logic [1:0]        perm_q;
  logic [WORD_W-1:0] paddr_q;

  logic [SEG_IW-1:0] seg_idx;
  logic [WORD_W-1:0] seg_sel;
  logic [WORD_W-1:0] grp_pri_w, grp_sec_w, cmp_w;
  logic [1:0]        perm_w;
  logic [WORD_W-1:0] grp_cur;

  assign seg_idx = req_vaddr_i[WORD_W-1 -: SEG_IW];
  assign seg_sel = seg_regs_i[seg_idx*WORD_W +: WORD_W];

  hpt_hash u_hash (
    .vsid_i     (seg_sel[VSID_W-1:0]),
    .page_idx_i (req_vaddr_i[27:12]),
    .cfg_i      (tbl_cfg_i),
    .grp_pri_o  (grp_pri_w),
    .grp_sec_o  (grp_sec_w),
    .cmp_o      (cmp_w)
  );

  hpt_perm u_perm (
    .instr_i (ins_q),
    .write_i (wr_q),
    .user_i  (usr_q),
    .ks_i    (ks_q),
    .kp_i    (kp_q),
    .nx_i    (nx_q),
    .guard_i (mem_rdata_i[PTE_G_BIT]),
    .pp_i    (mem_rdata_i[1:0]),
    .perm_o  (perm_w)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q      <= ST_IDLE;
      idx_q     <= '0;
      sec_q     <= 1'b0;
      ins_q     <= 1'b0;
      wr_q      <= 1'b0;
      usr_q     <= 1'b0;
      ks_q      <= 1'b0;
      kp_q      <= 1'b0;
      nx_q      <= 1'b0;
      off_q     <= '0;
      cmp_q     <= '0;
      grp_pri_q <= '0;
      grp_sec_q <= '0;
      done_q    <= 1'b0;
      found_q   <= 1'b0;
      perm_q    <= PERM_NONE;
      paddr_q   <= '0;
    end else begin
      done_q <= 1'b0;
      case (st_q)
        ST_IDLE: begin
          if (req_valid_i) begin
            ins_q     <= req_instr_i;
            wr_q      <= req_write_i;
            usr_q     <= req_user_i;
            ks_q      <= seg_sel[SEG_KS_BIT];
            kp_q      <= seg_sel[SEG_KP_BIT];
            nx_q      <= seg_sel[SEG_NX_BIT];
            off_q     <= req_vaddr_i[OFF_W-1:0];
            cmp_q     <= cmp_w;
            grp_pri_q <= grp_pri_w;
            grp_sec_q <= grp_sec_w;
            sec_q     <= 1'b0;
            idx_q     <= '0;
            st_q      <= ST_UP;
          end
        end
        ST_UP: begin
          if (mem_valid_i) begin
            if (mem_rdata_i == cmp_q) begin
              st_q <= ST_LO;
            end else if (idx_q == LAST_SLOT) begin
              if (!sec_q) begin
                sec_q            <= 1'b1;
                idx_q            <= '0;
                cmp_q[PTE_H_BIT] <= 1'b1;
              end else begin
                st_q    <= ST_IDLE;
                done_q  <= 1'b1;
                found_q <= 1'b0;
                perm_q  <= PERM_NONE;
                paddr_q <= '0;
              end
            end else begin
              idx_q <= idx_q + 1'b1;
            end
          end
        end
        ST_LO: begin
          if (mem_valid_i) begin
            st_q    <= ST_IDLE;
            done_q  <= 1'b1;
            found_q <= 1'b1;
            perm_q  <= perm_w;
            paddr_q <= {mem_rdata_i[WORD_W-1:OFF_W], off_q};
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign grp_cur    = sec_q ? grp_sec_q : grp_pri_q;
  assign mem_addr_o = grp_cur + WORD_W'({idx_q, 3'b000}) + ((st_q == ST_LO) ? WORD_W'(4) : '0);
  assign mem_req_o  = (st_q == ST_UP) || (st_q == ST_LO);
  assign busy_o     = (st_q != ST_IDLE);
  assign done_o     = done_q;
  assign found_o    = found_q;
  assign perm_o     = perm_q;
  assign paddr_o    = paddr_q;
  assign grp_pri_o  = grp_pri_q;
  assign grp_sec_o  = grp_sec_q;

  // R10
  mem_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_valid_i) |=> (mem_req_o && $stable(mem_addr_o)));

  // R10
  mem_align_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> (mem_addr_o[1:0] == 2'b00));

  // R11
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  // R11
  busy_ignore_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && req_valid_i) |=> ($stable(grp_pri_o) && $stable(grp_sec_o)));

  // R3
  launch_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && !busy_o) |=> mem_req_o);

  // R5
  miss_result_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && !found_o) |-> (perm_o == PERM_NONE && paddr_o == '0));

  // R7
  perm_code_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> (perm_o != 2'd3));
endmodule

// File: tb/hpt_walker_bench.sv
`timescale 1ns/1ps
module hpt_walker_bench;
  typedef struct packed {
    logic [31:0] va;
    logic        ins;
    logic        wr;
    logic        usr;
    logic        ks;
    logic        kp;
    logic        nx;
    logic        g;
    logic [1:0]  pp;
    logic [1:0]  where;   // 0 none, 1 primary, 2 secondary
    logic [2:0]  slot;
    logic        ef;
    logic [1:0]  ep;
  } vec_t;

  localparam int NV = 14;
  localparam vec_t VECS [NV] = '{
    '{32'h1234_5678, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 3'd0, 1'b1, 2'd2},
    '{32'h2ABC_D123, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd1, 3'd3, 1'b1, 2'd0},
    '{32'h3000_1FFF, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd1, 3'd7, 1'b1, 2'd1},
    '{32'h4FED_C010, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd2, 3'd0, 1'b1, 2'd0},
    '{32'h5555_5AAA, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 2'd1, 2'd2, 3'd5, 1'b1, 2'd1},
    '{32'h6013_0444, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd2, 2'd1, 3'd2, 1'b1, 2'd2},
    '{32'h7F00_0001, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 3'd1, 1'b1, 2'd0},
    '{32'h8123_4567, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 2'd0, 2'd1, 3'd4, 1'b1, 2'd2},
    '{32'h9ABC_0000, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 2'd2, 2'd1, 3'd0, 1'b1, 2'd0},
    '{32'hA000_0FF0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 2'd2, 3'd7, 1'b1, 2'd0},
    '{32'hB765_4321, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 2'd2, 2'd1, 3'd6, 1'b1, 2'd2},
    '{32'hCDEF_0123, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd2, 2'd0, 3'd0, 1'b0, 2'd0},
    '{32'hD246_8ACE, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd1, 2'd2, 3'd2, 1'b1, 2'd2},
    '{32'hE111_2222, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 2'd3, 2'd1, 3'd5, 1'b1, 2'd1}
  };
  localparam logic [31:0] CFG = 32'h0200_0003;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] req_va = '0;
  logic        req_ins = 1'b0, req_wr = 1'b0, req_usr = 1'b0;
  logic [511:0] segs = '0;
  logic        mem_req, mem_valid = 1'b0;
  logic [31:0] mem_addr, mem_rdata = '0;
  logic        busy, done, found;
  logic [31:0] paddr, grp_pri, grp_sec;
  logic [1:0]  perm;

  int total = 0;
  int bad = 0;
  int reads = 0;
  int ph = 0;
  bit finished = 0;
  logic [31:0] lat_addr = '0;
  logic [31:0] mem [logic [31:0]];

  always #5 clk = ~clk;

  hpt_walker u_hpt_walker (
    .clk_i(clk), .rst_ni(rst_n), .req_valid_i(req_valid), .req_vaddr_i(req_va),
    .req_instr_i(req_ins), .req_write_i(req_wr), .req_user_i(req_usr),
    .seg_regs_i(segs), .tbl_cfg_i(CFG), .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_valid_i(mem_valid), .mem_rdata_i(mem_rdata), .busy_o(busy), .done_o(done),
    .found_o(found), .paddr_o(paddr), .perm_o(perm), .grp_pri_o(grp_pri), .grp_sec_o(grp_sec)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory model: one cycle pending, one cycle valid
  always @(negedge clk) begin
    case (ph)
      0: if (mem_req) begin lat_addr = mem_addr; ph = 1; end
      1: begin
        chk("R10 address held", mem_addr, lat_addr);
        mem_valid <= 1'b1;
        mem_rdata <= mem.exists(lat_addr) ? mem[lat_addr] : 32'h0;
        reads++;
        ph = 2;
      end
      default: begin mem_valid <= 1'b0; ph = 0; end
    endcase
  end

  function automatic logic [23:0] vsid_of(input int n);
    return 24'hA5C3E1 ^ (24'(n) * 24'h013579);
  endfunction

  function automatic logic [31:0] grp_of(input logic [31:0] h);
    return (CFG & 32'hFE00_0000) | (CFG & 32'h01FF_0000) |
           ((((h >> 10) & CFG) & 32'h1FF) << 16) | ((h & 32'h3FF) << 6);
  endfunction

  task automatic wait_done(input string tag);
    for (int i = 0; i < 500; i++) begin
      @(negedge clk);
      if (done) return;
    end
    chk({tag, " timeout"}, 32'd0, 32'd1);
  endtask

  initial begin
    #1_000_000;
    if (!finished) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    for (int n = 0; n < 16; n++) segs[n*32 +: 32] = {8'h00, vsid_of(n)};
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 done", {31'b0, done}, 32'd0);
    chk("R1 found", {31'b0, found}, 32'd0);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    chk("R1 perm", {30'b0, perm}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      automatic vec_t t = VECS[v];
      automatic int sn = int'(t.va[31:28]);
      automatic logic [23:0] vs = vsid_of(sn);
      automatic logic [31:0] h1 = ({13'b0, vs[18:0]}) ^ ((t.va >> 12) & 32'hFFFF);
      automatic logic [31:0] h2 = h1 ^ 32'h7FFFF;
      automatic logic [31:0] gp = grp_of(h1);
      automatic logic [31:0] gs = grp_of(h2);
      automatic logic [31:0] cmp = {1'b1, vs, 1'b0, t.va[27:22]};
      automatic logic [19:0] rpn = t.va[31:12] ^ 20'h5A5A5;
      automatic logic [31:0] low = {rpn, 8'h00, t.g, 1'b0, t.pp};
      automatic int exp_reads = (t.where == 2'd1) ? int'(t.slot) + 2 :
                                (t.where == 2'd2) ? int'(t.slot) + 10 : 16;
      segs[sn*32 +: 32] = {1'b0, t.ks, t.kp, t.nx, 4'h0, vs};
      mem.delete();
      for (int s = 0; s < 8; s++) begin
        mem[gp + 32'(8*s)] = cmp ^ 32'h1;
        mem[gs + 32'(8*s)] = cmp ^ 32'h41;
      end
      if (t.where == 2'd1) begin
        mem[gp + 32'(8*t.slot)] = cmp;
        mem[gp + 32'(8*t.slot) + 4] = low;
        mem[gs] = cmp | 32'h40;
        mem[gs + 4] = 32'hFFFF_F002;
      end else if (t.where == 2'd2) begin
        mem[gp] = cmp | 32'h40;
        mem[gp + 4] = 32'hFFFF_F002;
        mem[gs + 32'(8*t.slot)] = cmp | 32'h40;
        mem[gs + 32'(8*t.slot) + 4] = low;
      end
      reads = 0;
      req_va = t.va; req_ins = t.ins; req_wr = t.wr; req_usr = t.usr;
      req_valid = 1'b1;
      @(negedge clk);
      req_valid = 1'b0;
      chk($sformatf("R2 grp_pri v%0d", v), grp_pri, gp);
      chk($sformatf("R3 grp_sec v%0d", v), grp_sec, gs);
      wait_done($sformatf("R11 v%0d", v));
      chk($sformatf("R5 R6 found v%0d", v), {31'b0, found}, {31'b0, t.ef});
      chk($sformatf("R6 R7 R8 perm v%0d", v), {30'b0, perm}, {30'b0, t.ep});
      chk($sformatf("R9 paddr v%0d", v), paddr, t.ef ? {rpn, t.va[11:0]} : 32'h0);
      chk($sformatf("R4 R12 reads v%0d", v), 32'(reads), 32'(exp_reads));
      @(negedge clk);
      chk($sformatf("R11 done pulse v%0d", v), {31'b0, done}, 32'd0);
      segs[sn*32 +: 32] = {8'h00, vs};
    end

    // R11 request while busy is ignored: repeat vector 0
    begin
      automatic vec_t t = VECS[0];
      automatic int sn = int'(t.va[31:28]);
      automatic logic [23:0] vs = vsid_of(sn);
      automatic logic [31:0] h1 = ({13'b0, vs[18:0]}) ^ ((t.va >> 12) & 32'hFFFF);
      automatic logic [31:0] gp = grp_of(h1);
      automatic logic [31:0] cmp = {1'b1, vs, 1'b0, t.va[27:22]};
      automatic logic [19:0] rpn = t.va[31:12] ^ 20'h5A5A5;
      mem.delete();
      mem[gp + 32'd16] = cmp;
      mem[gp + 32'd20] = {rpn, 12'h002};
      reads = 0;
      req_va = t.va; req_ins = 1'b0; req_wr = 1'b0; req_usr = 1'b0;
      req_valid = 1'b1;
      @(negedge clk);
      req_va = 32'hF0F0_F0F0; req_wr = 1'b1;
      repeat (3) @(negedge clk);
      req_valid = 1'b0;
      wait_done("R11 busy");
      chk("R11 busy ignored grp_pri", grp_pri, gp);
      chk("R11 busy ignored paddr", paddr, {rpn, t.va[11:0]});
      chk("R11 busy ignored perm", {30'b0, perm}, 32'd2);
      chk("R12 busy reads", 32'(reads), 32'd4);
      @(negedge clk);
      chk("R11 idle after busy", {31'b0, busy}, 32'd0);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule